// File: doc/BRIEF.md
# Selectable Reference Divider Chain

This block takes the 3.96 MHz crystal-rate clock of a radio tuning synthesizer and derives every slow timing signal from it. It produces a controller clock at half the input rate and four loop reference strobes at 20 kHz, 10 kHz, 9 kHz and 1 kHz. It also produces a 50 Hz time-of-day square wave. A 2-bit code picks which reference strobe goes to the phase comparator. All four taps also appear on their own outputs.

The ratios are not powers of two: 198, 396, 440, 3960 and 79200 input cycles. The 20 kHz stage is the root of one cascade, which halves it for 10 kHz, divides it by 20 for 1 kHz, and then divides by 10 again to toggle the 50 Hz output. The 9 kHz tap comes from its own divide-by-440 stage. A new select code is taken up only on a strobe of the reference that is currently in use. A change therefore never cuts a reference interval short.

Top module: `refdiv_chain`

## Requirements
- R1: The reset is synchronous and active low. While it is low every output is 0 and every counter is cleared. Input clock edges are counted from the first edge at which the reset is high, numbered 1, 2, 3 and so on.
- R2: `ctl_clk` changes state on every input edge. It is 1 after odd-numbered edges and 0 after even-numbered edges.
- R3: `tap_20k` is 1 for exactly one input cycle after each edge whose number is a multiple of 198, and 0 otherwise.
- R4: `tap_10k` is 1 for one cycle after each edge whose number is a multiple of 396. It only ever coincides with a `tap_20k` strobe.
- R5: `tap_9k` is 1 for one cycle after each edge whose number is a multiple of 440.
- R6: `tap_1k` is 1 for one cycle after each edge whose number is a multiple of 3960. It only ever coincides with a `tap_20k` strobe.
- R7: `tod_out` toggles on every tenth `tap_1k` strobe, in the same cycle as that strobe. It is 0 before edge 39600, 1 from edge 39600 up to edge 79200, and so on. This is a 50% duty 50 Hz wave.
- R8: `ref_pulse` follows the tap chosen by the adopted code {ref_sel[1], ref_sel[0]}: 2'b11 selects 20 kHz, 2'b10 selects 10 kHz, 2'b01 selects 9 kHz and 2'b00 selects 1 kHz. Each `ref_pulse` lasts one cycle.
- R9: A change of `ref_sel` is adopted only at an edge where the currently adopted reference strobes. That strobe still belongs to the old reference, and the new reference gives the pulses that follow.
- R10: The code present on `ref_sel` while reset is low is the adopted code when reset is released. Its first pulse comes one full period of that reference after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Crystal-rate input clock (3.96 MHz) |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_sel | input | 2 | Reference select code |
| ctl_clk | output | 1 | Controller clock, input divided by two |
| ref_pulse | output | 1 | Selected reference strobe to the phase comparator |
| tap_20k | output | 1 | 20 kHz one-cycle strobe |
| tap_10k | output | 1 | 10 kHz one-cycle strobe |
| tap_9k | output | 1 | 9 kHz one-cycle strobe |
| tap_1k | output | 1 | 1 kHz one-cycle strobe |
| tod_out | output | 1 | 50 Hz time-of-day square wave |

## Verification
Every output goes through exactly one register after its counter compare. A strobe whose counter reaches its last value before edge k is therefore visible in the cycle after edge k. The bench numbers edges from reset release and samples on the falling edge. For every edge it compares each output with an expected value computed as a modulus of the edge number. `ref_pulse` has the same one-register delay as the taps. A select change is checked by moving `ref_sel` partway through a period and expecting one more pulse at the old spacing, then pulses only at the new spacing. The `tod_out` check runs past edge 79200 so that it sees both the rising toggle and the falling toggle.

// File: rtl/refdiv_pkg.sv
// Package: shared select code and default ratios of the divider chain.
// Assumes a 3.96 MHz input clock; ratios give 20k/10k/9k/1k/50 Hz.
package refdiv_pkg;

    typedef enum logic [1:0] {
        REF_1K  = 2'b00,
        REF_9K  = 2'b01,
        REF_10K = 2'b10,
        REF_20K = 2'b11
    } ref_code_e;

    localparam int unsigned DEF_OSC_TO_FAST  = 198;
    localparam int unsigned DEF_FAST_TO_HALF = 2;
    localparam int unsigned DEF_OSC_TO_NINE  = 440;
    localparam int unsigned DEF_FAST_TO_KHZ  = 20;
    localparam int unsigned DEF_KHZ_TO_FLIP  = 10;

endpackage

// File: rtl/refdiv_stage.sv
// Module: one modulo-MOD counting stage of the chain.
// Counts enabled cycles and raises a combinational tick on the last
// enabled count, then wraps to zero. Assumes MOD >= 2.
module refdiv_stage #(
    parameter int unsigned MOD = 198
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int unsigned W    = (MOD > 2) ? $clog2(MOD) : 1;
    localparam logic [W-1:0] LAST = W'(MOD - 1);

    logic [W-1:0] cnt;

    assign tick = en && (cnt == LAST);

    // Purpose: advance the count on enable, wrap after the last value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (en) begin
            cnt <= (cnt == LAST) ? '0 : cnt + W'(1);
        end
    end

    AST_STAGE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (cnt == '0)); // R3

endmodule

// File: rtl/refdiv_sel.sv
// Module: reference selector.
// Holds the adopted select code and passes the chosen tick on as a
// registered strobe. A new code is adopted only on a tick of the
// currently adopted reference. Assumes ticks[] is indexed by code.
module refdiv_sel (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] code_in,
    input  logic [3:0] ticks,
    output logic       strobe
);
    import refdiv_pkg::*;

    ref_code_e sel_q;
    logic      sel_tick;

    assign sel_tick = ticks[sel_q];

    // Purpose: load the code during reset, swap it only at a boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q  <= ref_code_e'(code_in);
            strobe <= 1'b0;
        end else begin
            strobe <= sel_tick;
            if (sel_tick) begin
                sel_q <= ref_code_e'(code_in);
            end
        end
    end

    AST_SEL_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$stable(sel_q)) |-> $past(sel_tick)); // R9

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> !strobe); // R8

endmodule

// File: rtl/refdiv_chain.sv
// Module: top of the selectable reference divider chain.
// Derives a half-rate controller clock, four reference strobes and a
// 50 Hz time-of-day wave from one oscillator clock. The 20 kHz stage
// feeds the 10 kHz, 1 kHz and 50 Hz stages; 9 kHz has its own stage.
// Assumes the chain is always clocked (no power gating modelled).
module refdiv_chain #(
    parameter int unsigned OSC_TO_FAST  = refdiv_pkg::DEF_OSC_TO_FAST,
    parameter int unsigned FAST_TO_HALF = refdiv_pkg::DEF_FAST_TO_HALF,
    parameter int unsigned OSC_TO_NINE  = refdiv_pkg::DEF_OSC_TO_NINE,
    parameter int unsigned FAST_TO_KHZ  = refdiv_pkg::DEF_FAST_TO_KHZ,
    parameter int unsigned KHZ_TO_FLIP  = refdiv_pkg::DEF_KHZ_TO_FLIP
) (
    input  logic       osc_clk,
    input  logic       rst_n,
    input  logic [1:0] ref_sel,
    output logic       ctl_clk,
    output logic       ref_pulse,
    output logic       tap_20k,
    output logic       tap_10k,
    output logic       tap_9k,
    output logic       tap_1k,
    output logic       tod_out
);
    import refdiv_pkg::*;

    logic tick_fast;
    logic tick_half;
    logic tick_nine;
    logic tick_khz;
    logic tick_flip;
    logic [3:0] tick_by_code;

    refdiv_stage #(.MOD(OSC_TO_FAST)) u_fast (
        .clk(osc_clk), .rst_n(rst_n), .en(1'b1), .tick(tick_fast)
    );

    refdiv_stage #(.MOD(FAST_TO_HALF)) u_half (
        .clk(osc_clk), .rst_n(rst_n), .en(tick_fast), .tick(tick_half)
    );

    refdiv_stage #(.MOD(OSC_TO_NINE)) u_nine (
        .clk(osc_clk), .rst_n(rst_n), .en(1'b1), .tick(tick_nine)
    );

    refdiv_stage #(.MOD(FAST_TO_KHZ)) u_khz (
        .clk(osc_clk), .rst_n(rst_n), .en(tick_fast), .tick(tick_khz)
    );

    refdiv_stage #(.MOD(KHZ_TO_FLIP)) u_flip (
        .clk(osc_clk), .rst_n(rst_n), .en(tick_khz), .tick(tick_flip)
    );

    // Purpose: index the reference ticks by select code.
    always_comb begin
        tick_by_code          = '0;
        tick_by_code[REF_1K]  = tick_khz;
        tick_by_code[REF_9K]  = tick_nine;
        tick_by_code[REF_10K] = tick_half;
        tick_by_code[REF_20K] = tick_fast;
    end

    refdiv_sel u_sel (
        .clk(osc_clk), .rst_n(rst_n), .code_in(ref_sel),
        .ticks(tick_by_code), .strobe(ref_pulse)
    );

    // Purpose: register the taps, toggle controller clock and 50 Hz wave.
    always_ff @(posedge osc_clk) begin
        if (!rst_n) begin
            ctl_clk <= 1'b0;
            tap_20k <= 1'b0;
            tap_10k <= 1'b0;
            tap_9k  <= 1'b0;
            tap_1k  <= 1'b0;
            tod_out <= 1'b0;
        end else begin
            ctl_clk <= ~ctl_clk;
            tap_20k <= tick_fast;
            tap_10k <= tick_half;
            tap_9k  <= tick_nine;
            tap_1k  <= tick_khz;
            if (tick_flip) begin
                tod_out <= ~tod_out;
            end
        end
    end

    AST_CTL_TOGGLES: assert property (@(posedge osc_clk) disable iff (!rst_n)
        rst_n |=> (ctl_clk != $past(ctl_clk))); // R2

    AST_HALF_IN_FAST: assert property (@(posedge osc_clk) disable iff (!rst_n)
        tap_10k |-> tap_20k); // R4

    AST_KHZ_IN_FAST: assert property (@(posedge osc_clk) disable iff (!rst_n)
        tap_1k |-> tap_20k); // R6

    AST_TOD_ON_KHZ: assert property (@(posedge osc_clk) disable iff (!rst_n)
        !$stable(tod_out) |-> tap_1k); // R7

    AST_REF_FROM_TAP: assert property (@(posedge osc_clk) disable iff (!rst_n)
        ref_pulse |-> (tap_20k || tap_10k || tap_9k || tap_1k)); // R8

endmodule

// File: tb/tb_refdiv_chain.sv
module tb_refdiv_chain;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 190000;
    localparam logic [1:0] VSEL [4] = '{2'b11, 2'b10, 2'b01, 2'b00};
    localparam int         VPER [4] = '{198, 396, 440, 3960};

    logic       osc_clk = 1'b0;
    logic       rst_n   = 1'b0;
    logic [1:0] ref_sel = 2'b00;
    logic ctl_clk, ref_pulse, tap_20k, tap_10k, tap_9k, tap_1k, tod_out;

    int checks   = 0;
    int failures = 0;
    int k        = 0;
    bit done     = 0;

    refdiv_chain dut (
        .osc_clk(osc_clk), .rst_n(rst_n), .ref_sel(ref_sel),
        .ctl_clk(ctl_clk), .ref_pulse(ref_pulse), .tap_20k(tap_20k),
        .tap_10k(tap_10k), .tap_9k(tap_9k), .tap_1k(tap_1k), .tod_out(tod_out)
    );

    always #(CLK_PERIOD/2) osc_clk = ~osc_clk;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // one edge, then sample at the falling edge
    task automatic step();
        @(posedge osc_clk);
        k++;
        @(negedge osc_clk);
    endtask

    task automatic do_reset(input logic [1:0] sel);
        @(negedge osc_clk);
        rst_n   = 1'b0;
        ref_sel = sel;
        repeat (3) @(negedge osc_clk);
        rst_n = 1'b1;
        k     = 0;
    endtask

    initial begin
        bit bad2, bad3, bad4, bad5, bad6, bad7, bad8;
        int a2, e2, a3, e3, a4, e4, a5, e5, a6, e6, a7, e7, a8, e8;

        // R1: outputs low while reset held
        @(negedge osc_clk);
        rst_n = 1'b0;
        repeat (3) @(negedge osc_clk);
        check({ctl_clk, ref_pulse, tap_20k, tap_10k, tap_9k, tap_1k, tod_out} == 7'b0,
              "R1 outputs in reset",
              int'({ctl_clk, ref_pulse, tap_20k, tap_10k, tap_9k, tap_1k, tod_out}), 0);

        // long run with code 00: every output against its edge-number formula
        do_reset(2'b00);
        {bad2, bad3, bad4, bad5, bad6, bad7, bad8} = '0;
        for (int i = 0; i < 79205; i++) begin
            step();
            if (!bad2 && ctl_clk !== 1'(k % 2)) begin bad2 = 1; a2 = ctl_clk; e2 = k % 2; end
            if (!bad3 && tap_20k !== (k % 198 == 0)) begin bad3 = 1; a3 = tap_20k; e3 = k; end
            if (!bad4 && tap_10k !== (k % 396 == 0)) begin bad4 = 1; a4 = tap_10k; e4 = k; end
            if (!bad5 && tap_9k !== (k % 440 == 0)) begin bad5 = 1; a5 = tap_9k; e5 = k; end
            if (!bad6 && tap_1k !== (k % 3960 == 0)) begin bad6 = 1; a6 = tap_1k; e6 = k; end
            if (!bad7 && tod_out !== 1'((k / 39600) % 2)) begin bad7 = 1; a7 = tod_out; e7 = k; end
            if (!bad8 && ref_pulse !== (k % 3960 == 0)) begin bad8 = 1; a8 = ref_pulse; e8 = k; end
        end
        check(!bad2, "R2 ctl_clk parity", a2, e2);
        check(!bad3, "R3 tap_20k at edge (expected shows edge)", a3, e3);
        check(!bad4, "R4 tap_10k at edge", a4, e4);
        check(!bad5, "R5 tap_9k at edge", a5, e5);
        check(!bad6, "R6 tap_1k at edge", a6, e6);
        check(!bad7, "R7 tod_out at edge", a7, e7);
        check(!bad8, "R8 ref_pulse code 00 at edge", a8, e8);

        // table walk: each code adopted at reset gives its own period (R8, R10)
        for (int v = 0; v < 4; v++) begin
            bit bad;
            int at;
            bad = 0;
            at  = 0;
            do_reset(VSEL[v]);
            for (int i = 0; i < 2 * VPER[v] + 3; i++) begin
                step();
                if (!bad && ref_pulse !== (k % VPER[v] == 0)) begin bad = 1; at = k; end
            end
            check(!bad, $sformatf("R8 R10 code %0b period %0d, mismatch edge", VSEL[v], VPER[v]),
                  at, 0);
        end

        // R9: 20k -> 1k change mid-period; old pulse at 198, then only 3960
        begin
            bit bad;
            int at;
            bad = 0;
            at  = 0;
            do_reset(2'b11);
            for (int i = 0; i < 4200; i++) begin
                step();
                if (k == 100) ref_sel = 2'b00;
                if (!bad && ref_pulse !== (k == 198 || k == 3960)) begin bad = 1; at = k; end
            end
            check(!bad, "R9 switch 20k->1k, mismatch edge", at, 0);
        end

        // R9: 1k -> 20k change; waits for 3960, then 198 spacing
        begin
            bit bad;
            int at;
            bad = 0;
            at  = 0;
            do_reset(2'b00);
            for (int i = 0; i < 4400; i++) begin
                step();
                if (k == 500) ref_sel = 2'b11;
                if (!bad && ref_pulse !== (k >= 3960 && (k - 3960) % 198 == 0)) begin
                    bad = 1;
                    at  = k;
                end
            end
            check(!bad, "R9 switch 1k->20k, mismatch edge", at, 0);
        end

        // R1: reset mid-run clears state; first 20k strobe again at edge 198
        begin
            do_reset(2'b11);
            for (int i = 0; i < 197; i++) step();
            check(tap_20k == 1'b0 && ref_pulse == 1'b0, "R1 no strobe before edge 198",
                  int'(tap_20k), 0);
            step();
            check(tap_20k == 1'b1 && ref_pulse == 1'b1, "R1 strobe at edge 198 after reset",
                  int'(ref_pulse), 1);
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge osc_clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule